// File: doc/BRIEF.md
# Partitioned Time-Multiplexed FIR Filter

This block is a finite impulse response filter that trades throughput for area. Its taps are split into equal groups (lanes). Every lane owns one multiplier and one accumulator, and it walks through its own taps one per system-clock cycle. All lanes walk in step. A sample therefore occupies the block for a number of clock slots equal to the lane length, so the system clock has to run that many times faster than the sample rate. One lane holding every tap is the fully serial case.

Two ways of merging the lane results are built in, and a parameter selects one of them. In merge mode a separate adder tree sums the lane accumulators after the last tap. In chained mode the lanes add no tree. In one extra slot, each lane's accumulator adder takes the running total from the lane after it, so the full sum settles in lane 0's accumulator. This costs one more clock per sample and one more clock of latency. In both modes a final output register holds the result. The coefficients are fixed at elaboration. Samples arrive with a one-cycle valid strobe, and results leave with a one-cycle valid strobe.

Top module: `fir_partly_serial`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid` is 0 and `out_sample` is 0.
- R2: For the n-th accepted sample x[n], the output is the sum over i = 0..NTAPS-1 of c[i]*x[n-i]. Tap 0 applies to the newest sample, c[i] is the signed value at bits [i*CW +: CW] of COEFS, and samples from before the delay line filled count as 0.
- R3: The result width is DW+CW+ceil(log2(NTAPS)) bits, signed. The output is exact for the most negative and most positive sample values with no wrap.
- R4: The taps split into NPART lanes of NTAPS/NPART taps each, and lane p holds taps p*NTAPS/NPART onward. All lanes run in parallel, so in merge mode a sample occupies NTAPS/NPART clock slots.
- R5: In merge mode `out_valid` rises NTAPS/NPART+1 clocks after the edge that accepts the sample, and `out_sample` changes only with a valid pulse.
- R6: In chained mode (CASCADE=1) a sample occupies NTAPS/NPART+1 slots. The result appears NTAPS/NPART+2 clocks after acceptance and is the same value as in R2.
- R7: `in_valid` is accepted when the block is idle or in the last slot of the current sample. At any other time it is ignored and does not enter the delay line.
- R8: `out_valid` is a one-cycle pulse per accepted sample. It first appears for the NTAPS-th accepted sample.
- R9: With NPART=1 (fully serial) a sample occupies NTAPS slots and the results match R2.
- R10: Each accumulator restarts on the first tap of every sample and holds its value while the block is idle. Back-to-back samples at full rate do not leak into one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_sample | output | DW+CW+ceil(log2(NTAPS)) | Signed filter output |

## Verification
Three instances run side by side: merge mode, chained mode and fully serial. They share a sample stream: an impulse that reads out the coefficients in tap order, which exposes any mis-mapping of taps to lanes; a constant full-scale step; alternating extreme values that stress the sign and result width; and random data. Each instance is then driven separately at its own full rate and faster. Faster driving shows whether strobes that arrive mid-sample are dropped. A strobe held high for many cycles shows acceptance on the last slot and the accumulator restart. Each result is compared by value and by arrival cycle, which separates the one-clock latency difference between merge and chained modes.

// File: rtl/fir_ps_pkg.sv
package fir_ps_pkg;

  // Bits needed to hold a count that ranges over 0..n-1 (at least one).
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Exact result width for a sum of n products of dw by cw bit signed values.
  function automatic int acc_w(input int dw, input int cw, input int n);
    return dw + cw + ((n < 2) ? 0 : $clog2(n));
  endfunction

  // Clock slots a sample occupies: one per lane tap plus the chaining slot.
  function automatic int slot_count(input int plen, input bit chained);
    return plen + (chained ? 1 : 0);
  endfunction

endpackage

// File: rtl/fir_ps_taps.sv
module fir_ps_taps #(
  parameter int DW    = 8,
  parameter int NTAPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic [DW-1:0]         din,
  output logic [NTAPS*DW-1:0]   line
);
  logic [DW-1:0] stage_q [NTAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) stage_q[i] <= '0;
    end else if (shift) begin
      stage_q[0] <= din;
      for (int i = 1; i < NTAPS; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_flat
    assign line[g*DW +: DW] = stage_q[g];
  end
endmodule

// File: rtl/fir_ps_sequencer.sv
module fir_ps_sequencer #(
  parameter int NTAPS = 8,
  parameter int PLEN  = 4,
  parameter int SLOTS = 4,
  parameter int SW    = 3,
  parameter bit CASCADE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          accept,
  output logic          busy,
  output logic [SW-1:0] slot,
  output logic          last,
  output logic          first,
  output logic          tap_en,
  output logic          cas_en,
  output logic          done
);
  localparam int FW = fir_ps_pkg::cnt_w(NTAPS + 1);

  logic [FW-1:0] fill_q;
  logic          live_q;

  assign last   = busy && (slot == SW'(SLOTS - 1));
  assign accept = in_valid && (!busy || last);
  assign first  = busy && (slot == '0);
  assign tap_en = busy && (slot < SW'(PLEN));
  assign cas_en = CASCADE && busy && (slot == SW'(PLEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      fill_q <= '0;
      live_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last && live_q;
      if (accept) begin
        busy   <= 1'b1;
        slot   <= '0;
        live_q <= (fill_q >= FW'(NTAPS - 1));
        if (fill_q != FW'(NTAPS)) fill_q <= fill_q + 1'b1;
      end else if (last) begin
        busy <= 1'b0;
        slot <= '0;
      end else if (busy) begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fir_ps_lane.sv
module fir_ps_lane #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int AW   = 19,
  parameter int PLEN = 4,
  parameter int KW   = 2,
  parameter logic [PLEN*CW-1:0] LCOEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tap_en,
  input  logic                 cas_en,
  input  logic                 first,
  input  logic [KW-1:0]        idx,
  input  logic [PLEN*DW-1:0]   samples,
  input  logic signed [AW-1:0] cas_in,
  output logic signed [AW-1:0] acc_o,
  output logic signed [AW-1:0] sum_o
);
  logic signed [DW-1:0]    x_sel;
  logic signed [CW-1:0]    c_sel;
  logic signed [DW+CW-1:0] prod;
  logic signed [AW-1:0]    operand;
  logic signed [AW-1:0]    base;
  logic signed [AW-1:0]    acc_q;

  assign x_sel   = samples[idx*DW +: DW];
  assign c_sel   = LCOEF[idx*CW +: CW];
  assign prod    = x_sel * c_sel;
  assign operand = cas_en ? cas_in : AW'(prod);
  assign base    = first ? '0 : acc_q;
  assign sum_o   = base + operand;
  assign acc_o   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                acc_q <= '0;
    else if (tap_en || cas_en) acc_q <= sum_o;
  end
endmodule

// File: rtl/fir_partly_serial.sv
module fir_partly_serial #(
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int NTAPS   = 8,
  parameter int NPART   = 2,
  parameter bit CASCADE = 1'b0,
  parameter logic [NTAPS*CW-1:0] COEFS =
    {8'h01, 8'h80, 8'h04, 8'hFF, 8'h02, 8'h7F, 8'hFB, 8'h03},
  localparam int AW = fir_ps_pkg::acc_w(DW, CW, NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_sample
);
  localparam int PLEN  = NTAPS / NPART;
  localparam int SLOTS = fir_ps_pkg::slot_count(PLEN, CASCADE);
  localparam int SW    = fir_ps_pkg::cnt_w(SLOTS + 1);
  localparam int KW    = fir_ps_pkg::cnt_w(PLEN);

  logic                accept, busy, last, first, tap_en, cas_en, done;
  logic [SW-1:0]       slot;
  logic [KW-1:0]       idx;
  logic [NTAPS*DW-1:0] line;
  logic signed [AW-1:0] acc_v [NPART];
  logic signed [AW-1:0] sum_v [NPART];
  logic signed [AW-1:0] cin_v [NPART];
  logic [NPART*AW-1:0]  acc_bus;
  logic signed [AW-1:0] merged;

  fir_ps_sequencer #(
    .NTAPS(NTAPS), .PLEN(PLEN), .SLOTS(SLOTS), .SW(SW), .CASCADE(CASCADE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .accept(accept),
    .busy(busy), .slot(slot), .last(last), .first(first),
    .tap_en(tap_en), .cas_en(cas_en), .done(done)
  );

  fir_ps_taps #(.DW(DW), .NTAPS(NTAPS)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift(accept), .din(in_sample), .line(line)
  );

  assign idx = tap_en ? slot[KW-1:0] : '0;

  for (genvar p = 0; p < NPART; p++) begin : g_lane
    if (p == NPART - 1) begin : g_tail
      assign cin_v[p] = '0;
    end else begin : g_link
      assign cin_v[p] = sum_v[p+1];
    end

    fir_ps_lane #(
      .DW(DW), .CW(CW), .AW(AW), .PLEN(PLEN), .KW(KW),
      .LCOEF(COEFS[p*PLEN*CW +: PLEN*CW])
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .tap_en(tap_en), .cas_en(cas_en),
      .first(first), .idx(idx),
      .samples(line[p*PLEN*DW +: PLEN*DW]),
      .cas_in(cin_v[p]), .acc_o(acc_v[p]), .sum_o(sum_v[p])
    );

    assign acc_bus[p*AW +: AW] = acc_v[p];
  end

  if (CASCADE) begin : g_chain
    assign merged = acc_v[0];
  end else begin : g_tree
    always_comb begin
      merged = '0;
      for (int p = 0; p < NPART; p++) merged = merged + acc_v[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= done;
      if (done) out_sample <= merged;
    end
  end
endmodule

// File: rtl/fir_ps_checker.sv
module fir_ps_checker #(
  parameter int AW    = 19,
  parameter int SW    = 3,
  parameter int NPART = 2,
  parameter int SLOTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                accept,
  input logic                busy,
  input logic                last,
  input logic                done,
  input logic [SW-1:0]       slot,
  input logic [NPART*AW-1:0] acc_bus,
  input logic                out_valid,
  input logic [AW-1:0]       out_sample
);
  p_accept_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && slot == '0));

  p_slot_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && slot == $past(slot) + 1'b1));

  p_idle_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !in_valid) |=> !busy);

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && SLOTS > 1) |=> !out_valid);

  p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(done));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(out_sample));

  p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(acc_bus));
endmodule

bind fir_partly_serial fir_ps_checker #(
  .AW(AW), .SW(SW), .NPART(NPART), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .accept(accept),
  .busy(busy), .last(last), .done(done), .slot(slot), .acc_bus(acc_bus),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/sim_fir_partly_serial.sv
module sim_fir_partly_serial;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int NT = 8;
  localparam int AW = DW + CW + 3;
  localparam logic [NT*CW-1:0] CP =
    {8'h01, 8'h80, 8'h04, 8'hFF, 8'h02, 8'h7F, 8'hFB, 8'h03};

  typedef struct { longint v; longint c; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] vld = '0;
  logic signed [DW-1:0] din = '0;
  logic ov0, ov1, ov2;
  logic signed [AW-1:0] os0, os1, os2;

  always #5 clk = ~clk;

  fir_partly_serial #(.DW(DW), .CW(CW), .NTAPS(NT), .NPART(2), .CASCADE(1'b0), .COEFS(CP))
    u0 (.clk(clk), .rst_n(rst_n), .in_valid(vld[0]), .in_sample(din), .out_valid(ov0), .out_sample(os0));
  fir_partly_serial #(.DW(DW), .CW(CW), .NTAPS(NT), .NPART(2), .CASCADE(1'b1), .COEFS(CP))
    u1 (.clk(clk), .rst_n(rst_n), .in_valid(vld[1]), .in_sample(din), .out_valid(ov1), .out_sample(os1));
  fir_partly_serial #(.DW(DW), .CW(CW), .NTAPS(NT), .NPART(1), .CASCADE(1'b0), .COEFS(CP))
    u2 (.clk(clk), .rst_n(rst_n), .in_valid(vld[2]), .in_sample(din), .out_valid(ov2), .out_sample(os2));

  int     slots [3] = '{4, 5, 8};
  exp_t   qs [3][$];
  longint hist [3][NT];
  int     nacc [3];
  longint free_e [3];
  longint cyc = 0;
  int     checks = 0;
  int     fails = 0;
  bit     finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef(input int i);
    return longint'($signed(CP[i*CW +: CW]));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; the model decides acceptance per R7.
  task automatic step(input logic [2:0] mask, input logic signed [DW-1:0] val);
    longint e;
    longint s;
    @(negedge clk);
    din = val;
    vld = mask;
    e = cyc + 1;
    for (int d = 0; d < 3; d++) begin
      if (mask[d] && e >= free_e[d]) begin
        free_e[d] = e + slots[d];
        for (int i = NT - 1; i > 0; i--) hist[d][i] = hist[d][i-1];
        hist[d][0] = longint'(val);
        nacc[d]++;
        if (nacc[d] >= NT) begin
          s = 0;
          for (int i = 0; i < NT; i++) s += coef(i) * hist[d][i];
          qs[d].push_back('{v: s, c: e + slots[d] + 1});
        end
      end
    end
  endtask

  task automatic send(input logic [2:0] mask, input logic signed [DW-1:0] val,
                      input int period);
    step(mask, val);
    for (int k = 1; k < period; k++) step(3'b000, '0);
  endtask

  task automatic mon(input int d, input logic ov, input logic signed [AW-1:0] os);
    exp_t  e;
    string rq;
    rq = (d == 0) ? "R2/R5" : (d == 1) ? "R6" : "R9";
    if (ov) begin
      if (qs[d].size() == 0) begin
        chk(1'b0, "R8", $sformatf("unexpected valid on u%0d", d), 1, 0);
      end else begin
        e = qs[d].pop_front();
        chk(longint'(os) == e.v, rq, $sformatf("value u%0d", d), longint'(os), e.v);
        chk(cyc == e.c, rq, $sformatf("arrival cycle u%0d", d), cyc, e.c);
      end
    end else if (qs[d].size() != 0 && qs[d][0].c <= cyc) begin
      e = qs[d].pop_front();
      chk(1'b0, "R8", $sformatf("missing valid u%0d", d), cyc, e.c);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon(0, ov0, os0);
      mon(1, ov1, os1);
      mon(2, ov2, os2);
    end
  end

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 3; d++) begin
      nacc[d] = 0;
      free_e[d] = 0;
      for (int i = 0; i < NT; i++) hist[d][i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(ov0 == 0 && os0 == 0, "R1", "u0 during reset", longint'(os0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ov0 == 0 && os0 == 0, "R1", "u0 idle after reset", longint'(os0), 0);
    chk(ov1 == 0 && os1 == 0, "R1", "u1 idle after reset", longint'(os1), 0);
    chk(ov2 == 0 && os2 == 0, "R1", "u2 idle after reset", longint'(os2), 0);

    // R4 R2: impulse reads the coefficients out in tap order
    for (int k = 0; k < 7; k++) send(3'b111, 8'sd0, 9);
    send(3'b111, 8'sd1, 9);
    for (int k = 0; k < 8; k++) send(3'b111, 8'sd0, 9);
    // R3: full-scale step and alternating extremes
    for (int k = 0; k < 10; k++) send(3'b111, 8'sd127, 9);
    for (int k = 0; k < 10; k++) send(3'b111, -8'sd128, 9);
    for (int k = 0; k < 12; k++) send(3'b111, (k % 2 == 0) ? 8'sd127 : -8'sd128, 9);
    for (int k = 0; k < 20; k++) send(3'b111, DW'($urandom_range(255)), 9);

    // R10 R5: merge mode at full rate
    for (int k = 0; k < 16; k++) send(3'b001, DW'($urandom_range(255)), 4);
    // R6: chained mode at its own full rate, then too fast (R7 drops)
    for (int k = 0; k < 16; k++) send(3'b010, DW'($urandom_range(255)), 5);
    for (int k = 0; k < 16; k++) send(3'b010, DW'($urandom_range(255)), 4);
    // R7: strobe held high, accepted only on the last slot
    for (int k = 0; k < 40; k++) step(3'b001, DW'($urandom_range(255)));
    step(3'b000, '0);
    // R9: fully serial at full rate and too fast
    for (int k = 0; k < 10; k++) send(3'b100, DW'($urandom_range(255)), 8);
    for (int k = 0; k < 12; k++) send(3'b100, DW'($urandom_range(255)), 3);

    repeat (30) @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(qs[d].size() == 0, "R8", $sformatf("results left pending u%0d", d), qs[d].size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule